// File: doc/BRIEF.md
# On-Demand Route Discovery Controller

This block decides where an outgoing data unit goes when routes are found only on demand. A send request names a destination. A small route cache is searched for a valid entry. On a hit, the block names the cached next hop one cycle later. On a miss, it broadcasts a route request and arms a timeout. It repeats the request until a matching route reply comes back or the retry budget is spent. When the budget is spent it raises a no-route pulse for that destination.

The block also serves the rest of the node's control traffic. Incoming requests and replies teach it reverse and forward routes. Replies meant for another originator are passed on as unicast along the learned reverse path. A broken neighbour link purges every route through that neighbour and triggers an error broadcast. A received error drops one specific route. Hello packets go out on a fixed period. Received hellos install one-hop neighbour routes and are never forwarded.

Control packets enter and leave as typed descriptors carrying a type, originator, destination, previous hop and hop count. Physical transmission is done elsewhere.

Top module: `route_disc_ctl`

## Requirements
- R1: Packet type is a 2-bit code: 00 request, 01 reply, 10 error, 11 hello. `txBcast` is 1 for request, error and hello, and 0 for reply.
- R2: When `sendReq` is accepted and the cache holds a valid route to `sendDst`, `dataValid` pulses in the next cycle with `dataDst` = `sendDst` and `dataNextHop` = the cached next hop. No request is sent.
- R3: When `sendReq` misses, `busy` rises and a request is broadcast with `txSrc` = own address, `txDst` = target and `txHops` = 0. The request is re-sent after each timeout with no answer.
- R4: While discovery waits, a reply with `rxDst` = own address and `rxSrc` = target ends discovery. `dataValid` pulses in the next cycle with `dataNextHop` = `rxFrom`. The route stays cached for later sends.
- R5: If no reply arrives, discovery gives up once `reqLimit`+1 requests have timed out. `noRoute` then pulses with `noRouteDst` = target, and `busy` falls in the same cycle.
- R6: A received request writes a reverse route whose destination is `rxSrc` and whose next hop is `rxFrom`.
- R7: A reply whose `rxDst` is another node is sent on as unicast in the next cycle when a route to `rxDst` exists. It keeps `txSrc`/`txDst`, gets `txNextHop` = the reverse next hop and `txHops` = `rxHops`+1. Without such a route it is dropped.
- R8: A `linkDown` pulse invalidates every route whose next hop is `linkNbr` and broadcasts an error with `txDst` = `linkNbr`. Routes through other neighbours remain usable.
- R9: A hello with `txSrc` = own address and `txHops` = 0 goes out every `HELLO_PERIOD` cycles when the transmit slot is free. A received hello installs a one-hop route to `rxFrom` and causes no transmission.
- R10: A received error invalidates the route to `rxDst` only if that route's next hop is `rxFrom`.
- R11: A `sendReq` while `busy` is high is ignored: no data output, and the target is not changed.
- R12: The cache holds `DEPTH` entries. A learned destination already present is rewritten in place, but only if the new hop count is not larger. A new destination takes the lowest free slot, or, when the cache is full, a victim slot that rotates from slot 0 upward.
- R13: After reset the cache is empty and `busy`, `dataValid`, `noRoute` and `txValid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sendReq | input | 1 | Request to send data to `sendDst` |
| sendDst | input | ADDR_W | Data destination |
| busy | output | 1 | Discovery in progress |
| dataValid | output | 1 | Data may leave now |
| dataDst | output | ADDR_W | Destination of released data |
| dataNextHop | output | ADDR_W | Neighbour to hand the data to |
| noRoute | output | 1 | Discovery failed (pulse) |
| noRouteDst | output | ADDR_W | Destination that could not be reached |
| rxValid | input | 1 | Received control descriptor valid |
| rxType | input | 2 | Received packet type |
| rxSrc | input | ADDR_W | Originator field |
| rxDst | input | ADDR_W | Destination field |
| rxFrom | input | ADDR_W | Neighbour it arrived from |
| rxHops | input | HOP_W | Hop count field |
| linkDown | input | 1 | Neighbour link found broken (pulse) |
| linkNbr | input | ADDR_W | The broken neighbour |
| reqLimit | input | LIM_W | Retries allowed after the first request |
| txValid | output | 1 | Outgoing control descriptor valid |
| txType | output | 2 | Outgoing packet type |
| txBcast | output | 1 | 1 broadcast, 0 unicast |
| txSrc | output | ADDR_W | Originator field |
| txDst | output | ADDR_W | Destination field |
| txNextHop | output | ADDR_W | Unicast neighbour (0 for broadcast) |
| txHops | output | HOP_W | Hop count field |

## Verification
The hardest situations to reach are the ones that need many quiet cycles or a full cache. One is the give-up path, which is only reached after several timeout rounds with nothing arriving. Another is victim replacement, which needs every slot occupied first. The bench reaches give-up by sending to unknown destinations with a small retry budget and keeping the receive side silent, then counts the request broadcasts seen before the no-route pulse. It fills the cache with nine distinct neighbour hellos, plus one repeated hello that must not allocate a slot, and then shows which destination was evicted by the miss that follows.

// File: rtl/rdc_pkg.sv
package rdc_pkg;

  typedef enum logic [1:0] {
    PKT_REQ   = 2'b00,
    PKT_REP   = 2'b01,
    PKT_ERR   = 2'b10,
    PKT_HELLO = 2'b11
  } pktType_e;

  typedef enum logic [2:0] {
    TX_NONE,
    TX_FWDREP,
    TX_ERR,
    TX_REQ,
    TX_HELLO
  } txSel_e;

  typedef struct packed {
    logic   cacheWr;      // learn a route from the rx descriptor
    logic   invLink;      // purge routes through linkNbr
    logic   invErr;       // drop route named by a received error
    logic   tgtLoad;      // capture sendDst as discovery target
    logic   errLatch;     // capture linkNbr for the error broadcast
    logic   timerLoad;    // arm the reply timeout
    txSel_e txSel;        // which descriptor to emit
    logic   dataHit;      // release data along cached route
    logic   dataRep;      // release data along fresh reply
    logic   noRouteFire;  // discovery abandoned
  } ctlStrobe_t;

endpackage

// File: rtl/rdc_datapath.sv
module rdc_datapath
  import rdc_pkg::*;
#(
  parameter int ADDR_W       = 8,
  parameter int HOP_W        = 4,
  parameter int DEPTH        = 8,
  parameter int LIM_W        = 3,
  parameter int TIMEOUT      = 32,
  parameter int HELLO_PERIOD = 256,
  parameter logic [ADDR_W-1:0] MY_ADDR = 'h01
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctlStrobe_t        stb,
  input  logic              lookupTgt,
  input  logic [ADDR_W-1:0] sendDst,
  input  logic [1:0]        rxType,
  input  logic [ADDR_W-1:0] rxSrc,
  input  logic [ADDR_W-1:0] rxDst,
  input  logic [ADDR_W-1:0] rxFrom,
  input  logic [HOP_W-1:0]  rxHops,
  input  logic [ADDR_W-1:0] linkNbr,
  input  logic [LIM_W-1:0]  reqLimit,
  output logic              lookHit,
  output logic              revHit,
  output logic              tgtMatch,
  output logic              timerDone,
  output logic              retryDone,
  output logic              helloTick,
  output logic              dataValid,
  output logic [ADDR_W-1:0] dataDst,
  output logic [ADDR_W-1:0] dataNextHop,
  output logic              noRoute,
  output logic [ADDR_W-1:0] noRouteDst,
  output logic              txValid,
  output logic [1:0]        txType,
  output logic              txBcast,
  output logic [ADDR_W-1:0] txSrc,
  output logic [ADDR_W-1:0] txDst,
  output logic [ADDR_W-1:0] txNextHop,
  output logic [HOP_W-1:0]  txHops
);

  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int TMR_W = $clog2(TIMEOUT + 1);
  localparam int HC_W  = (HELLO_PERIOD > 1) ? $clog2(HELLO_PERIOD) : 1;

  // route cache
  logic [ADDR_W-1:0] cDst [DEPTH];
  logic [ADDR_W-1:0] cNh  [DEPTH];
  logic [HOP_W-1:0]  cHops[DEPTH];
  logic [DEPTH-1:0]  cVld;
  logic [IDX_W-1:0]  victim;

  logic [ADDR_W-1:0] target, errAddr;
  logic [TMR_W-1:0]  timer;
  logic [LIM_W:0]    retryCnt;
  logic [HC_W-1:0]   helloCnt;

  logic [ADDR_W-1:0] lookAddr, lookNh, revNh, wrDst;
  logic [HOP_W-1:0]  wrHops, hopsInc;
  logic              matchFound, freeFound, wrEn;
  logic [IDX_W-1:0]  matchIdx, freeIdx, wrIdx;

  pktType_e rxT;
  assign rxT = pktType_e'(rxType);

  assign lookAddr = lookupTgt ? target : sendDst;
  assign hopsInc  = (rxHops == '1) ? rxHops : rxHops + HOP_W'(1);
  assign wrDst    = (rxT == PKT_HELLO) ? rxFrom : rxSrc;
  assign wrHops   = (rxT == PKT_HELLO) ? HOP_W'(1) : hopsInc;

  // two search ports: send/target and reverse path
  always_comb begin
    lookHit = 1'b0;
    lookNh  = '0;
    revHit  = 1'b0;
    revNh   = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (cVld[i] && cDst[i] == lookAddr) begin
        lookHit = 1'b1;
        lookNh  = cNh[i];
      end
      if (cVld[i] && cDst[i] == rxDst) begin
        revHit = 1'b1;
        revNh  = cNh[i];
      end
    end
  end

  // slot selection: existing entry, lowest free slot, else rotating victim
  always_comb begin
    matchFound = 1'b0;
    matchIdx   = '0;
    freeFound  = 1'b0;
    freeIdx    = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (cVld[i] && cDst[i] == wrDst) begin
        matchFound = 1'b1;
        matchIdx   = IDX_W'(i);
      end
      if (!cVld[i]) begin
        freeFound = 1'b1;
        freeIdx   = IDX_W'(i);
      end
    end
    wrIdx = matchFound ? matchIdx : (freeFound ? freeIdx : victim);
    wrEn  = stb.cacheWr && (!matchFound || (wrHops <= cHops[matchIdx]));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cVld   <= '0;
      victim <= '0;
    end else begin
      if (wrEn) begin
        cDst[wrIdx]  <= wrDst;
        cNh[wrIdx]   <= rxFrom;
        cHops[wrIdx] <= wrHops;
        cVld[wrIdx]  <= 1'b1;
        if (!matchFound && !freeFound)
          victim <= (victim == IDX_W'(DEPTH - 1)) ? '0 : victim + IDX_W'(1);
      end
      for (int i = 0; i < DEPTH; i++) begin
        if (stb.invLink &&
            (((wrEn && wrIdx == IDX_W'(i)) ? rxFrom : cNh[i]) == linkNbr))
          cVld[i] <= 1'b0;
        if (stb.invErr && cDst[i] == rxDst && cNh[i] == rxFrom)
          cVld[i] <= 1'b0;
      end
    end
  end

  // discovery context, timeout and hello period
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      target   <= '0;
      errAddr  <= '0;
      timer    <= '0;
      retryCnt <= '0;
      helloCnt <= '0;
    end else begin
      if (stb.tgtLoad)  target  <= sendDst;
      if (stb.errLatch) errAddr <= linkNbr;
      if (stb.timerLoad)     timer <= TMR_W'(TIMEOUT);
      else if (timer != '0)  timer <= timer - TMR_W'(1);
      if (stb.tgtLoad)                 retryCnt <= '0;
      else if (stb.txSel == TX_REQ)    retryCnt <= retryCnt + (LIM_W+1)'(1);
      helloCnt <= helloTick ? '0 : helloCnt + HC_W'(1);
    end
  end

  assign tgtMatch  = (rxSrc == target);
  assign timerDone = (timer == '0);
  assign retryDone = (retryCnt > {1'b0, reqLimit});
  assign helloTick = (helloCnt == HC_W'(HELLO_PERIOD - 1));

  // registered outputs
  pktType_e txTypeQ;
  assign txType = txTypeQ;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      txValid     <= 1'b0;
      txTypeQ     <= PKT_REQ;
      txBcast     <= 1'b0;
      txSrc       <= '0;
      txDst       <= '0;
      txNextHop   <= '0;
      txHops      <= '0;
      dataValid   <= 1'b0;
      dataDst     <= '0;
      dataNextHop <= '0;
      noRoute     <= 1'b0;
      noRouteDst  <= '0;
    end else begin
      txValid <= (stb.txSel != TX_NONE);
      unique case (stb.txSel)
        TX_FWDREP: begin
          txTypeQ <= PKT_REP;  txBcast <= 1'b0;
          txSrc   <= rxSrc;    txDst   <= rxDst;
          txNextHop <= revNh;  txHops  <= hopsInc;
        end
        TX_ERR: begin
          txTypeQ <= PKT_ERR;  txBcast <= 1'b1;
          txSrc   <= MY_ADDR;  txDst   <= errAddr;
          txNextHop <= '0;     txHops  <= '0;
        end
        TX_REQ: begin
          txTypeQ <= PKT_REQ;  txBcast <= 1'b1;
          txSrc   <= MY_ADDR;  txDst   <= target;
          txNextHop <= '0;     txHops  <= '0;
        end
        TX_HELLO: begin
          txTypeQ <= PKT_HELLO; txBcast <= 1'b1;
          txSrc   <= MY_ADDR;   txDst   <= '0;
          txNextHop <= '0;      txHops  <= '0;
        end
        default: ;
      endcase
      dataValid   <= stb.dataHit || stb.dataRep;
      dataDst     <= stb.dataHit ? lookAddr : target;
      dataNextHop <= stb.dataHit ? lookNh : rxFrom;
      noRoute     <= stb.noRouteFire;
      noRouteDst  <= target;
    end
  end

  // no valid route may still point at a neighbour just reported broken
  logic staleHit;
  always_comb begin
    staleHit = 1'b0;
    for (int i = 0; i < DEPTH; i++)
      if (cVld[i] && cNh[i] == errAddr) staleHit = 1'b1;
  end

  a_r8_no_stale_route: assert property (@(posedge clk) disable iff (!rst_n)
    stb.invLink |=> !staleHit);

  a_r11_target_held: assert property (@(posedge clk) disable iff (!rst_n)
    (lookupTgt && !stb.tgtLoad) |=> $stable(target));

  a_r7_reply_unicast: assert property (@(posedge clk) disable iff (!rst_n)
    (txValid && txTypeQ == PKT_REP) |-> !txBcast);

endmodule

// File: rtl/rdc_ctrl.sv
module rdc_ctrl
  import rdc_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] MY_ADDR = 'h01
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sendReq,
  input  logic              rxValid,
  input  logic [1:0]        rxType,
  input  logic [ADDR_W-1:0] rxDst,
  input  logic              linkDown,
  input  logic              lookHit,
  input  logic              revHit,
  input  logic              tgtMatch,
  input  logic              timerDone,
  input  logic              retryDone,
  input  logic              helloTick,
  output ctlStrobe_t        stb,
  output logic              lookupTgt,
  output logic              busy
);

  typedef enum logic [1:0] {ST_IDLE, ST_SEND_REQ, ST_WAIT} state_e;

  state_e   state, stateNxt;
  logic     errPend, helloPend, wantReq, rxIsRep, forUs;
  pktType_e rxT;

  assign rxT     = pktType_e'(rxType);
  assign rxIsRep = rxValid && (rxT == PKT_REP);
  assign forUs   = (rxDst == MY_ADDR);
  assign lookupTgt = (state != ST_IDLE);
  assign busy      = (state != ST_IDLE);

  always_comb begin
    stb          = '0;
    stb.txSel    = TX_NONE;
    stateNxt     = state;
    wantReq      = 1'b0;
    stb.cacheWr  = rxValid && (rxT != PKT_ERR);
    stb.invErr   = rxValid && (rxT == PKT_ERR);
    stb.invLink  = linkDown;
    stb.errLatch = linkDown;

    unique case (state)
      ST_IDLE: begin
        if (sendReq) begin
          if (lookHit) stb.dataHit = 1'b1;
          else begin
            stb.tgtLoad = 1'b1;
            stateNxt    = ST_SEND_REQ;
          end
        end
      end
      ST_SEND_REQ: begin
        if (lookHit) begin
          stb.dataHit = 1'b1;
          stateNxt    = ST_IDLE;
        end else wantReq = 1'b1;
      end
      ST_WAIT: begin
        if (rxIsRep && forUs && tgtMatch) begin
          stb.dataRep = 1'b1;
          stateNxt    = ST_IDLE;
        end else if (timerDone) begin
          if (retryDone) begin
            stb.noRouteFire = 1'b1;
            stateNxt        = ST_IDLE;
          end else stateNxt = ST_SEND_REQ;
        end
      end
      default: stateNxt = ST_IDLE;
    endcase

    // one descriptor per cycle: relay > error > request > hello
    if (rxIsRep && !forUs && revHit) stb.txSel = TX_FWDREP;
    else if (errPend)                stb.txSel = TX_ERR;
    else if (wantReq) begin
      stb.txSel     = TX_REQ;
      stb.timerLoad = 1'b1;
      stateNxt      = ST_WAIT;
    end
    else if (helloPend)              stb.txSel = TX_HELLO;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      errPend   <= 1'b0;
      helloPend <= 1'b0;
    end else begin
      state <= stateNxt;
      if (linkDown)                     errPend <= 1'b1;
      else if (stb.txSel == TX_ERR)     errPend <= 1'b0;
      if (helloTick)                    helloPend <= 1'b1;
      else if (stb.txSel == TX_HELLO)   helloPend <= 1'b0;
    end
  end

  // a freshly armed timeout must not read as expired one cycle later
  a_r3_timer_armed: assert property (@(posedge clk) disable iff (!rst_n)
    (stb.txSel == TX_REQ) |=> !timerDone);

  // once retries are spent, the next expiry ends discovery
  a_r5_giveup_exits: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WAIT && timerDone && retryDone && !rxIsRep) |=> state == ST_IDLE);

endmodule

// File: rtl/route_disc_ctl.sv
module route_disc_ctl
  import rdc_pkg::*;
#(
  parameter int ADDR_W       = 8,
  parameter int HOP_W        = 4,
  parameter int DEPTH        = 8,
  parameter int LIM_W        = 3,
  parameter int TIMEOUT      = 32,
  parameter int HELLO_PERIOD = 256,
  parameter logic [ADDR_W-1:0] MY_ADDR = 'h01
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sendReq,
  input  logic [ADDR_W-1:0] sendDst,
  output logic              busy,
  output logic              dataValid,
  output logic [ADDR_W-1:0] dataDst,
  output logic [ADDR_W-1:0] dataNextHop,
  output logic              noRoute,
  output logic [ADDR_W-1:0] noRouteDst,
  input  logic              rxValid,
  input  logic [1:0]        rxType,
  input  logic [ADDR_W-1:0] rxSrc,
  input  logic [ADDR_W-1:0] rxDst,
  input  logic [ADDR_W-1:0] rxFrom,
  input  logic [HOP_W-1:0]  rxHops,
  input  logic              linkDown,
  input  logic [ADDR_W-1:0] linkNbr,
  input  logic [LIM_W-1:0]  reqLimit,
  output logic              txValid,
  output logic [1:0]        txType,
  output logic              txBcast,
  output logic [ADDR_W-1:0] txSrc,
  output logic [ADDR_W-1:0] txDst,
  output logic [ADDR_W-1:0] txNextHop,
  output logic [HOP_W-1:0]  txHops
);

  ctlStrobe_t stb;
  logic lookupTgt, lookHit, revHit, tgtMatch, timerDone, retryDone, helloTick;

  rdc_ctrl #(.ADDR_W(ADDR_W), .MY_ADDR(MY_ADDR)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .sendReq(sendReq), .rxValid(rxValid),
    .rxType(rxType), .rxDst(rxDst), .linkDown(linkDown),
    .lookHit(lookHit), .revHit(revHit), .tgtMatch(tgtMatch),
    .timerDone(timerDone), .retryDone(retryDone), .helloTick(helloTick),
    .stb(stb), .lookupTgt(lookupTgt), .busy(busy)
  );

  rdc_datapath #(
    .ADDR_W(ADDR_W), .HOP_W(HOP_W), .DEPTH(DEPTH), .LIM_W(LIM_W),
    .TIMEOUT(TIMEOUT), .HELLO_PERIOD(HELLO_PERIOD), .MY_ADDR(MY_ADDR)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .stb(stb), .lookupTgt(lookupTgt),
    .sendDst(sendDst), .rxType(rxType), .rxSrc(rxSrc), .rxDst(rxDst),
    .rxFrom(rxFrom), .rxHops(rxHops), .linkNbr(linkNbr), .reqLimit(reqLimit),
    .lookHit(lookHit), .revHit(revHit), .tgtMatch(tgtMatch),
    .timerDone(timerDone), .retryDone(retryDone), .helloTick(helloTick),
    .dataValid(dataValid), .dataDst(dataDst), .dataNextHop(dataNextHop),
    .noRoute(noRoute), .noRouteDst(noRouteDst),
    .txValid(txValid), .txType(txType), .txBcast(txBcast), .txSrc(txSrc),
    .txDst(txDst), .txNextHop(txNextHop), .txHops(txHops)
  );

  a_r5_noroute_idle: assert property (@(posedge clk) disable iff (!rst_n)
    noRoute |-> !busy);

  a_r4_single_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    !(dataValid && noRoute));

  a_r3_req_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (txValid && txType == 2'b00) |-> busy);

  a_r9_hello_origin: assert property (@(posedge clk) disable iff (!rst_n)
    (txValid && txType == 2'b11) |-> (txSrc == MY_ADDR && txHops == '0 && txBcast));

endmodule

// File: tb/route_disc_ctl_bench.sv
module route_disc_ctl_bench;

  localparam int AW = 8;
  localparam int HW = 4;
  localparam int LW = 3;
  localparam int PER = 40;
  localparam int TO  = 10;
  localparam logic [AW-1:0] MY = 8'h01;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, sendReq, rxValid, linkDown;
  logic [AW-1:0] sendDst, rxSrc, rxDst, rxFrom, linkNbr;
  logic [1:0] rxType;
  logic [HW-1:0] rxHops;
  logic [LW-1:0] reqLimit;
  logic busy, dataValid, noRoute, txValid, txBcast;
  logic [AW-1:0] dataDst, dataNextHop, noRouteDst, txSrc, txDst, txNextHop;
  logic [1:0] txType;
  logic [HW-1:0] txHops;

  route_disc_ctl #(.ADDR_W(AW), .HOP_W(HW), .DEPTH(8), .LIM_W(LW),
    .TIMEOUT(TO), .HELLO_PERIOD(PER), .MY_ADDR(MY)) u_route_disc_ctl (
    .clk(clk), .rst_n(rst_n), .sendReq(sendReq), .sendDst(sendDst),
    .busy(busy), .dataValid(dataValid), .dataDst(dataDst),
    .dataNextHop(dataNextHop), .noRoute(noRoute), .noRouteDst(noRouteDst),
    .rxValid(rxValid), .rxType(rxType), .rxSrc(rxSrc), .rxDst(rxDst),
    .rxFrom(rxFrom), .rxHops(rxHops), .linkDown(linkDown), .linkNbr(linkNbr),
    .reqLimit(reqLimit), .txValid(txValid), .txType(txType), .txBcast(txBcast),
    .txSrc(txSrc), .txDst(txDst), .txNextHop(txNextHop), .txHops(txHops));

  int nChk = 0, nFail = 0, reqSeen = 0;
  bit ended = 0;

  always @(negedge clk)
    if (rst_n === 1'b1 && txValid === 1'b1 && txType === 2'b00) reqSeen++;

  task automatic chkEq(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic idleIn;
    sendReq = 0; sendDst = '0; rxValid = 0; rxType = '0; rxSrc = '0;
    rxDst = '0; rxFrom = '0; rxHops = '0; linkDown = 0; linkNbr = '0;
  endtask

  task automatic doReset;
    rst_n = 0; idleIn();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  // returns at the negedge after the sampling edge
  task automatic doSend(input logic [AW-1:0] d);
    sendReq = 1; sendDst = d;
    @(negedge clk);
    sendReq = 0;
  endtask

  task automatic rxPkt(input logic [1:0] t, input logic [AW-1:0] s, input logic [AW-1:0] d,
                       input logic [AW-1:0] f, input logic [HW-1:0] h);
    rxValid = 1; rxType = t; rxSrc = s; rxDst = d; rxFrom = f; rxHops = h;
    @(negedge clk);
    rxValid = 0;
  endtask

  task automatic waitTx(input logic [1:0] t, input int lim, output bit found);
    found = 0;
    for (int k = 0; k < lim && !found; k++) begin
      if (txValid && txType == t) found = 1;
      else @(negedge clk);
    end
  endtask

  task automatic waitNoRoute(input int lim, output bit found);
    found = 0;
    for (int k = 0; k < lim && !found; k++) begin
      if (noRoute) found = 1;
      else @(negedge clk);
    end
  endtask

  task automatic expectHit(input string req, input logic [AW-1:0] d, input logic [AW-1:0] nh);
    doSend(d);
    chkEq({req, " dataValid"}, dataValid, 1);
    chkEq({req, " dataDst"}, dataDst, d);
    chkEq({req, " dataNextHop"}, dataNextHop, nh);
  endtask

  // miss followed by failed discovery with a single request
  task automatic expectMiss(input string req, input logic [AW-1:0] d);
    bit f;
    reqLimit = 0;
    doSend(d);
    chkEq({req, " no data on miss"}, dataValid, 0);
    waitTx(2'b00, 8, f);
    chkEq({req, " request seen"}, f, 1);
    chkEq({req, " request dst"}, txDst, d);
    waitNoRoute(4 * TO, f);
    chkEq({req, " gave up"}, f, 1);
    @(negedge clk);
  endtask

  task automatic testReset;   // R13
    chkEq("R13 busy", busy, 0);
    chkEq("R13 dataValid", dataValid, 0);
    chkEq("R13 noRoute", noRoute, 0);
    chkEq("R13 txValid", txValid, 0);
    expectMiss("R13 empty cache", 8'h20);
  endtask

  task automatic testHelloLearn;   // R9 R2
    rxPkt(2'b11, 8'h20, 8'h00, 8'h20, 0);
    chkEq("R9 rx hello not relayed", txValid && txSrc != MY, 0);
    expectHit("R2/R9 neighbour hit", 8'h20, 8'h20);
  endtask

  task automatic testReverse;   // R6 R12
    rxPkt(2'b00, 8'h30, 8'h77, 8'h21, 2);
    expectHit("R6 reverse route", 8'h30, 8'h21);
    rxPkt(2'b00, 8'h30, 8'h77, 8'h24, 6);
    expectHit("R12 longer path kept out", 8'h30, 8'h21);
  endtask

  task automatic testRelay;   // R7 R1
    rxPkt(2'b01, 8'h77, 8'h30, 8'h22, 3);
    chkEq("R7 relay valid", txValid && txType == 2'b01, 1);
    chkEq("R1 reply unicast", txBcast, 0);
    chkEq("R7 relay next hop", txNextHop, 8'h21);
    chkEq("R7 relay src", txSrc, 8'h77);
    chkEq("R7 relay dst", txDst, 8'h30);
    chkEq("R7 relay hops", txHops, 4);
    rxPkt(2'b01, 8'h77, 8'h55, 8'h22, 3);
    chkEq("R7 no reverse route dropped", txValid && txType == 2'b01, 0);
  endtask

  task automatic testDiscover;   // R3 R4 R1
    bit f;
    reqLimit = 3;
    doSend(8'h40);
    chkEq("R3 busy on miss", busy, 1);
    waitTx(2'b00, 8, f);
    chkEq("R3 request seen", f, 1);
    chkEq("R1 request broadcast", txBcast, 1);
    chkEq("R3 request src", txSrc, MY);
    chkEq("R3 request dst", txDst, 8'h40);
    chkEq("R3 request hops", txHops, 0);
    repeat (3) @(negedge clk);
    rxPkt(2'b01, 8'h40, MY, 8'h23, 2);
    chkEq("R4 data released", dataValid, 1);
    chkEq("R4 data next hop", dataNextHop, 8'h23);
    chkEq("R4 data dst", dataDst, 8'h40);
    chkEq("R4 busy cleared", busy, 0);
    @(negedge clk);
    expectHit("R4 route cached", 8'h40, 8'h23);
  endtask

  task automatic testGiveUp;   // R5 R3
    bit f;
    int r0;
    reqLimit = 2;
    r0 = reqSeen;
    doSend(8'h50);
    waitNoRoute(10 * TO, f);
    chkEq("R5 noRoute pulse", f, 1);
    chkEq("R5 noRouteDst", noRouteDst, 8'h50);
    chkEq("R5 busy low", busy, 0);
    @(negedge clk);
    chkEq("R3/R5 request count", reqSeen - r0, 3);
  endtask

  task automatic testBusyIgnore;   // R11
    bit f;
    reqLimit = 1;
    doSend(8'h60);
    doSend(8'h20);
    chkEq("R11 send while busy ignored", dataValid, 0);
    waitNoRoute(10 * TO, f);
    chkEq("R11 discovery completes", f, 1);
    chkEq("R11 target unchanged", noRouteDst, 8'h60);
    @(negedge clk);
  endtask

  task automatic testLinkDown;   // R8 R1
    bit f;
    linkDown = 1; linkNbr = 8'h21;
    @(negedge clk);
    linkDown = 0;
    waitTx(2'b10, 8, f);
    chkEq("R8 error sent", f, 1);
    chkEq("R1 error broadcast", txBcast, 1);
    chkEq("R8 error dst", txDst, 8'h21);
    @(negedge clk);
    expectHit("R8 other route kept", 8'h20, 8'h20);
    expectMiss("R8 route purged", 8'h30);
  endtask

  task automatic testRxError;   // R10
    rxPkt(2'b10, 8'h09, 8'h20, 8'h99, 0);
    expectHit("R10 wrong sender no effect", 8'h20, 8'h20);
    rxPkt(2'b10, 8'h09, 8'h40, 8'h23, 0);
    expectMiss("R10 route dropped", 8'h40);
  endtask

  task automatic testHelloPeriod;   // R9 R1
    bit f;
    int k;
    waitTx(2'b11, 2 * PER + 4, f);
    @(negedge clk);
    waitTx(2'b11, 2 * PER + 4, f);
    chkEq("R9 hello seen", f, 1);
    chkEq("R1 hello broadcast", txBcast, 1);
    chkEq("R9 hello src", txSrc, MY);
    chkEq("R9 hello hops", txHops, 0);
    k = 0;
    do begin
      @(negedge clk);
      k++;
    end while (!(txValid && txType == 2'b11) && k < 3 * PER);
    chkEq("R9 hello period", k, PER);
  endtask

  task automatic testReplace;   // R12
    doReset();
    for (int i = 0; i < 8; i++) rxPkt(2'b11, 8'h00, 8'h00, 8'h81 + 8'(i), 0);
    rxPkt(2'b11, 8'h00, 8'h00, 8'h82, 0);
    rxPkt(2'b11, 8'h00, 8'h00, 8'h89, 0);
    for (int i = 1; i < 9; i++) expectHit("R12 resident", 8'h81 + 8'(i), 8'h81 + 8'(i));
    expectMiss("R12 slot 0 evicted", 8'h81);
  endtask

  initial begin
    repeat (150000) @(negedge clk);
    if (!ended) begin
      nChk++; nFail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
      $finish;
    end
  end

  initial begin
    reqLimit = 0;
    doReset();
    testReset();
    testHelloLearn();
    testReverse();
    testRelay();
    testDiscover();
    testGiveUp();
    testBusyIgnore();
    testLinkDown();
    testRxError();
    testHelloPeriod();
    testReplace();
    ended = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end

endmodule